// File: doc/BRIEF.md
# ECC Error Capture and Injection Registers

This block sits beside a memory ECC decoder and gives software a small register window onto its error reports. When the decoder flags a correctable or an uncorrectable event, the block records the 34-bit address, the 64-bit data word, the 8-bit syndrome and the 14-bit requester ID of that event. It then sets a pending status bit and raises an interrupt. Each error group keeps its first record until software acknowledges it. A second event in the same group only sets an overflow bit.

For testing, software can corrupt the check bits of one chosen write. It loads an 8-bit XOR pattern and sets a trigger bit in the injection register. On the next write the decoder path reports, the block XORs the pattern into the outgoing check bits, and the trigger then clears itself. The injection register accepts a bus write only while the controller reports no pending writes.

Registers are 32 bits wide and addressed by word index. Reads are combinational from the register state.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset, status (index 2), config (index 0), injection (index 13) and all capture registers read 0, the mask register (index 1) reads 0x8000_0000, and `irq` is 0.
- R2: While both ECC enable bits [17:16] of the config register are 0, event pulses set no status bit and capture nothing.
- R3: A correctable event with no correctable record pending stores its details. Index 4 returns address[31:0]. Index 5 returns address[33:32] in bits [1:0] and the syndrome in bits [15:8]. Index 6 returns data[31:0] and index 7 returns data[63:32]. The requester ID appears in bits [29:16] of index 12. Status bit 0 is set.
- R4: An uncorrectable event with no uncorrectable record pending stores its details in the same layout at indices 8 to 11. Its requester ID appears in bits [13:0] of index 12. Status bit 2 is set.
- R5: An event whose group pending bit is already set leaves that group's record unchanged and sets the group's overflow bit: bit 1 for correctable, bit 3 for uncorrectable.
- R6: Writing ones to status positions [3:0] of the acknowledge register (index 3) clears exactly those status bits. Zero bits leave their status bits alone.
- R7: A correctable and an uncorrectable event in the same cycle set both pending bits and fill both records.
- R8: `irq` is the OR of the status bits whose per-bit mask bit (mask register [3:0], 1 = masked) is 0. It is forced to 0 while the global mask bit 31 is 1.
- R9: The injection register holds the XOR pattern in [23:16], a write-back enable in bit 24 and the trigger in bit 8. A bus write to it is ignored while `ctrl_busy` is 1. Bit 0 of index 14 reads back `ctrl_busy`.
- R10: While the trigger is set, `ecc_out` equals `ecc_in` XOR the pattern during a `wr_valid` cycle, and the trigger clears at the end of that cycle. Otherwise `ecc_out` equals `ecc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| ce_evt | input | 1 | Correctable error pulse from the decoder |
| ue_evt | input | 1 | Uncorrectable error pulse from the decoder |
| evt_addr | input | 34 | Address of the reported error |
| evt_data | input | 64 | Data word of the reported error |
| evt_synd | input | 8 | Syndrome of the reported error |
| evt_src | input | 14 | Requester ID of the reported error |
| ctrl_busy | input | 1 | Controller has writes pending |
| wr_valid | input | 1 | A write is leaving for memory this cycle |
| ecc_in | input | 8 | Check bits computed for that write |
| ecc_out | output | 8 | Check bits sent to memory |
| irq | output | 1 | Error interrupt |

## Verification
A wrong status bit shows on `irq` and at index 2 in the cycle after the event edge. A record overwritten while it should be frozen shows in the next read of the capture registers. A stuck or early-clearing trigger shows on `ecc_out` during the armed write or the write after it. The injection register is read back around each busy-gated write, so a write that should have been dropped is visible at once.

// File: rtl/ecc_err_regs.sv
module ecc_err_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ce_evt,
  input  logic        ue_evt,
  input  logic [33:0] evt_addr,
  input  logic [63:0] evt_data,
  input  logic [7:0]  evt_synd,
  input  logic [13:0] evt_src,
  input  logic        ctrl_busy,
  input  logic        wr_valid,
  input  logic [7:0]  ecc_in,
  output logic [7:0]  ecc_out,
  output logic        irq
);
  localparam logic [3:0] A_CFG = 4'd0, A_MASK = 4'd1, A_STAT = 4'd2, A_ACK = 4'd3,
    A_CEAL = 4'd4, A_CEAH = 4'd5, A_CEDL = 4'd6, A_CEDH = 4'd7,
    A_UEAL = 4'd8, A_UEAH = 4'd9, A_UEDL = 4'd10, A_UEDH = 4'd11,
    A_SRC = 4'd12, A_INJ = 4'd13, A_BUSY = 4'd14;

  logic [1:0]  ecc_en;
  logic        gmask;
  logic [3:0]  imask, stat, ack, cur, stat_nxt;
  logic [33:0] ce_addr, ue_addr;
  logic [63:0] ce_data, ue_data;
  logic [7:0]  ce_synd, ue_synd, inj_pat;
  logic [13:0] ce_src, ue_src;
  logic        inj_wb, inj_fwc, inj_wr, en, ce_hit, ue_hit, ce_cap, ue_cap;

  assign en     = |ecc_en;
  assign ack    = (bus_we && bus_addr == A_ACK) ? bus_wdata[3:0] : 4'b0;
  assign cur    = stat & ~ack;
  assign ce_hit = ce_evt & en;
  assign ue_hit = ue_evt & en;
  assign ce_cap = ce_hit & ~cur[0];
  assign ue_cap = ue_hit & ~cur[2];
  assign inj_wr = bus_we && bus_addr == A_INJ && !ctrl_busy;

  always_comb begin
    stat_nxt = cur;
    if (ce_hit) begin
      stat_nxt[0] = 1'b1;
      if (cur[0]) stat_nxt[1] = 1'b1;
    end
    if (ue_hit) begin
      stat_nxt[2] = 1'b1;
      if (cur[2]) stat_nxt[3] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecc_en  <= '0;
      gmask   <= 1'b1;
      imask   <= '0;
      stat    <= '0;
      ce_addr <= '0; ce_data <= '0; ce_synd <= '0; ce_src <= '0;
      ue_addr <= '0; ue_data <= '0; ue_synd <= '0; ue_src <= '0;
      inj_pat <= '0; inj_wb <= 1'b0; inj_fwc <= 1'b0;
    end else begin
      stat <= stat_nxt;
      if (bus_we && bus_addr == A_CFG) ecc_en <= bus_wdata[17:16];
      if (bus_we && bus_addr == A_MASK) begin
        gmask <= bus_wdata[31];
        imask <= bus_wdata[3:0];
      end
      if (ce_cap) begin
        ce_addr <= evt_addr; ce_data <= evt_data;
        ce_synd <= evt_synd; ce_src  <= evt_src;
      end
      if (ue_cap) begin
        ue_addr <= evt_addr; ue_data <= evt_data;
        ue_synd <= evt_synd; ue_src  <= evt_src;
      end
      if (inj_wr) begin
        inj_pat <= bus_wdata[23:16];
        inj_wb  <= bus_wdata[24];
        inj_fwc <= bus_wdata[8];
      end else if (wr_valid && inj_fwc) begin
        inj_fwc <= 1'b0;
      end
    end
  end

  assign ecc_out = ecc_in ^ (inj_fwc ? inj_pat : 8'h00);
  assign irq     = ~gmask & |(stat & ~imask);

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {14'b0, ecc_en, 16'b0};
      A_MASK:  bus_rdata = {gmask, 27'b0, imask};
      A_STAT:  bus_rdata = {28'b0, stat};
      A_CEAL:  bus_rdata = ce_addr[31:0];
      A_CEAH:  bus_rdata = {16'b0, ce_synd, 6'b0, ce_addr[33:32]};
      A_CEDL:  bus_rdata = ce_data[31:0];
      A_CEDH:  bus_rdata = ce_data[63:32];
      A_UEAL:  bus_rdata = ue_addr[31:0];
      A_UEAH:  bus_rdata = {16'b0, ue_synd, 6'b0, ue_addr[33:32]};
      A_UEDL:  bus_rdata = ue_data[31:0];
      A_UEDH:  bus_rdata = ue_data[63:32];
      A_SRC:   bus_rdata = {2'b0, ce_src, 2'b0, ue_src};
      A_INJ:   bus_rdata = {7'b0, inj_wb, inj_pat, 7'b0, inj_fwc, 8'b0};
      A_BUSY:  bus_rdata = {31'b0, ctrl_busy};
      default: bus_rdata = 32'b0;
    endcase
  end

  // R10
  fwc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_fwc && wr_valid && !(bus_we && bus_addr == A_INJ)) |=> !inj_fwc);
  // R5
  ce_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !ack[0]) |=> ($stable(ce_addr) && $stable(ce_data)));
  // R5
  ue_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && !ack[2]) |=> ($stable(ue_addr) && $stable(ue_data)));
  // R2
  dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((stat & ~$past(stat)) == 4'b0));
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_INJ && ctrl_busy) |=> ($stable(inj_pat) && $stable(inj_wb)));
  // R8
  gmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |-> !irq);
endmodule

// File: tb/sim_ecc_err_regs.sv
`timescale 1ns/1ps
module sim_ecc_err_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ce_evt = 1'b0, ue_evt = 1'b0;
  logic [33:0] evt_addr = '0;
  logic [63:0] evt_data = '0;
  logic [7:0] evt_synd = '0;
  logic [13:0] evt_src = '0;
  logic ctrl_busy = 1'b0, wr_valid = 1'b0;
  logic [7:0] ecc_in = '0, ecc_out;
  logic irq;

  always #10 clk = ~clk;

  ecc_err_regs u0 (.*);

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  logic mon_go = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always @(negedge clk) if (mon_go) begin
    item_t it;
    logic [31:0] act;
    it = q.pop_front();
    act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'b0, irq} : {24'b0, ecc_out};
    checks++;
    if (act !== it.exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    mon_go = 1'b1;
    @(negedge clk); #1 mon_go = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1 bus_addr = a;
    push(0, exp, tag);
  endtask

  task automatic irq_is(input logic exp, input string tag);
    @(posedge clk); #1;
    push(1, {31'b0, exp}, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1 bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_we = 1'b0;
  endtask

  task automatic evt(input logic ce, input logic ue, input logic [33:0] a,
                     input logic [63:0] d, input logic [7:0] s, input logic [13:0] id);
    @(posedge clk); #1 ce_evt = ce; ue_evt = ue; evt_addr = a; evt_data = d; evt_synd = s; evt_src = id;
    @(posedge clk); #1 ce_evt = 1'b0; ue_evt = 1'b0;
  endtask

  task automatic wr_cyc(input logic [7:0] cb, input logic [7:0] exp, input string tag);
    @(posedge clk); #1 wr_valid = 1'b1; ecc_in = cb;
    push(2, {24'b0, exp}, tag);
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(2, 32'h0, "R1 status");
    rd(1, 32'h8000_0000, "R1 mask");
    rd(0, 32'h0, "R1 config");
    rd(13, 32'h0, "R1 inject");
    rd(4, 32'h0, "R1 ce addr");
    irq_is(1'b0, "R1 irq");
    evt(1, 1, 34'h1_1111_1111, 64'h5, 8'h11, 14'h5);
    rd(2, 32'h0, "R2 disabled status");
    rd(4, 32'h0, "R2 disabled capture");
    wr(0, 32'h0003_0000);
    wr(1, 32'h0);
    evt(1, 0, 34'h3_1234_5678, 64'hDEAD_BEEF_0123_4567, 8'hA5, 14'h1ABC);
    rd(2, 32'h1, "R3 status");
    rd(4, 32'h1234_5678, "R3 addr lo");
    rd(5, 32'h0000_A503, "R3 addr hi synd");
    rd(6, 32'h0123_4567, "R3 data lo");
    rd(7, 32'hDEAD_BEEF, "R3 data hi");
    rd(12, 32'h1ABC_0000, "R3 src");
    irq_is(1'b1, "R8 irq ce");
    evt(1, 0, 34'h0_0000_0001, 64'h9, 8'h01, 14'h0002);
    rd(2, 32'h3, "R5 overflow");
    rd(4, 32'h1234_5678, "R5 frozen addr");
    rd(7, 32'hDEAD_BEEF, "R5 frozen data");
    evt(0, 1, 34'h2_CAFE_0000, 64'h1111_2222_3333_4444, 8'h03, 14'h0777);
    rd(2, 32'h7, "R4 status");
    rd(8, 32'hCAFE_0000, "R4 addr lo");
    rd(9, 32'h0000_0302, "R4 addr hi synd");
    rd(10, 32'h3333_4444, "R4 data lo");
    rd(11, 32'h1111_2222, "R4 data hi");
    rd(12, 32'h1ABC_0777, "R4 src");
    wr(3, 32'h3);
    rd(2, 32'h4, "R6 partial ack");
    irq_is(1'b1, "R8 irq ue");
    wr(1, 32'h8000_0000);
    irq_is(1'b0, "R8 global mask");
    wr(1, 32'h4);
    irq_is(1'b0, "R8 bit mask");
    wr(1, 32'h0);
    irq_is(1'b1, "R8 unmasked");
    wr(3, 32'h4);
    rd(2, 32'h0, "R6 full ack");
    irq_is(1'b0, "R8 irq cleared");
    evt(1, 1, 34'h1_0000_00F0, 64'hAB, 8'h77, 14'h0033);
    rd(2, 32'h5, "R7 both status");
    rd(4, 32'h0000_00F0, "R7 ce addr");
    rd(9, 32'h0000_7701, "R7 ue hi");
    rd(12, 32'h0033_0033, "R7 src");
    ctrl_busy = 1'b1;
    rd(14, 32'h1, "R9 busy reg");
    wr(13, 32'h01FF_0100);
    rd(13, 32'h0, "R9 busy ignores write");
    wr_cyc(8'h0F, 8'h0F, "R10 unarmed write");
    #1 ctrl_busy = 1'b0;
    rd(14, 32'h0, "R9 idle reg");
    wr(13, 32'h015A_0100);
    rd(13, 32'h015A_0100, "R9 inject fields");
    wr_cyc(8'h0F, 8'h55, "R10 xor applied");
    rd(13, 32'h015A_0000, "R10 trigger cleared");
    wr_cyc(8'h33, 8'h33, "R10 one shot");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule